// File: doc/BRIEF.md
# Prescaled Countdown Timer with Interrupt Request

This block is a per-processor countdown timer. Software loads a start value, chooses a power-of-two prescale through a 4-bit divide setting, and picks one-shot or periodic behaviour plus a mask bit and an 8-bit vector in a timer control word. Each time the count reaches zero the block raises an interrupt request that carries the vector toward an interrupt controller.

Registers are written and read through a plain address/data port. The write takes effect at the clock edge, and the read data is combinational from the selected register. The live counter is readable at any time. The request leaves on a valid/ready channel. Once `irq_valid` is high, it stays high with `irq_vector` stable until a cycle in which `irq_ready` is also high; that cycle is the handshake. If the controller holds `irq_ready` low, the block merges further expiries into the request already waiting. All counting is in block clock cycles.

Top module: `lcl_timer`

## Requirements
- R1: A write to the divide setting (address 0) keeps only bits 0, 1 and 3 of the data, and the rest read back as zero. Writing 0xFF reads back 0xB.
- R2: The prescale code is {bit3, bit1, bit0} of the divide setting. The counter steps once every 2^((code+1) mod 8) clocks. So 0xB steps every clock, 0x0 (the reset value) every 2 clocks, and 0x2 every 8 clocks.
- R3: A write to the initial count (address 1) loads the counter with that value at the write edge and restarts the prescaler. The first step follows one full prescale interval after the write edge.
- R4: In one-shot mode (control bit 17 = 0), the counter steps down to 0 and stays there. Reaching 0 raises exactly one request.
- R5: In periodic mode (control bit 17 = 1), the step after the counter reaches 0 reloads it with the initial count. A request is raised every N+1 steps.
- R6: When control bit 16 (mask) is set at the moment the count reaches 0, no request is raised.
- R7: A request carries control bits 7:0 as `irq_vector`. `irq_valid` and `irq_vector` hold steady until the cycle in which `irq_ready` is high.
- R8: An initial count of 0 stops the counter at 0 and raises no requests, in either mode.
- R9: A write to the timer control word (address 3) takes effect on the next step. After a one-shot expiry, switching to periodic mode reloads the initial count on the next step.
- R10: An expiry while a request waits unaccepted is merged into it. An expiry in the same cycle as the handshake raises a fresh request with the current vector.
- R11: After reset all registers read 0 and `irq_valid` is low.
- R12: Address 2 reads the live counter combinationally, and writes to address 2 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 2 | Write address (0 divide, 1 initial count, 2 current count, 3 control) |
| reg_wdata | input | 32 | Write data |
| reg_raddr | input | 2 | Read address |
| reg_rdata | output | 32 | Combinational read data |
| irq_valid | output | 1 | Interrupt request pending |
| irq_ready | input | 1 | Controller accepts the request |
| irq_vector | output | 8 | Vector of the pending request |

## Verification
The two functions that can fall in the same cycle are a fresh expiry and the handshake of the previous request. The bench runs a periodic count of 1, so the count expires on every second edge. It holds `irq_ready` low across several expiries and checks that they merge into one request: one accept then drops `irq_valid`. It then rewrites the vector and raises `irq_ready` exactly on an expiry edge. It judges the result by `irq_valid` staying high with the new vector on the following cycle.

// File: rtl/lcl_timer_pkg.sv
package lcl_timer_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] RA_DIV   = 2'd0;
  localparam logic [ADDR_W-1:0] RA_INIT  = 2'd1;
  localparam logic [ADDR_W-1:0] RA_CURR  = 2'd2;
  localparam logic [ADDR_W-1:0] RA_CTRL  = 2'd3;

  localparam int DIV_W      = 4;
  localparam logic [DIV_W-1:0] DIV_KEEP = 4'hB;
  localparam int SHIFT_W    = 3;
  localparam int VEC_W      = 8;
  localparam int CTRL_W     = 18;
  localparam int CTRL_MASK  = 16;
  localparam int CTRL_PER   = 17;

  // code = {d3,d1,d0}; shift = (code+1) mod 8
  function automatic logic [SHIFT_W-1:0] div_to_shift(input logic [DIV_W-1:0] d);
    logic [SHIFT_W-1:0] code;
    code = {d[3], d[1:0]};
    return code + 3'd1;
  endfunction
endpackage

// File: rtl/lcl_timer_regs.sv
module lcl_timer_regs
  import lcl_timer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  input  logic [CNT_W-1:0]  cur_cnt,
  output logic [DATA_W-1:0] rdata,
  output logic [DIV_W-1:0]  div_q,
  output logic [CNT_W-1:0]  init_q,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic              init_ld
);
  assign init_ld = we && (waddr == RA_INIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q  <= '0;
      init_q <= '0;
      ctrl_q <= '0;
    end else if (we) begin
      case (waddr)
        RA_DIV:  div_q  <= wdata[DIV_W-1:0] & DIV_KEEP;
        RA_INIT: init_q <= wdata[CNT_W-1:0];
        RA_CTRL: ctrl_q <= wdata[CTRL_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (raddr)
      RA_DIV:  rdata = DATA_W'(div_q);
      RA_INIT: rdata = DATA_W'(init_q);
      RA_CURR: rdata = DATA_W'(cur_cnt);
      default: rdata = DATA_W'(ctrl_q);
    endcase
  end
endmodule

// File: rtl/lcl_timer_prescale.sv
module lcl_timer_prescale
  import lcl_timer_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               restart,
  input  logic [SHIFT_W-1:0] shift,
  output logic               tick
);
  localparam int PRE_W = (1 << SHIFT_W) - 1;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] low_mask;

  assign low_mask = ~({PRE_W{1'b1}} << shift);
  assign tick     = &(pre_q | ~low_mask);

  always_ff @(posedge clk) begin
    if (!rst_n || restart) pre_q <= '0;
    else                   pre_q <= pre_q + 1'b1;
  end

  a_r3_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !tick || (shift == '0));
endmodule

// File: rtl/lcl_timer_counter.sv
module lcl_timer_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld,
  input  logic [CNT_W-1:0] ld_val,
  input  logic [CNT_W-1:0] init_q,
  input  logic             periodic,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt_q,
  output logic             expire
);
  logic running;
  logic at_zero;

  assign at_zero = (cnt_q == '0);
  assign running = (init_q != '0) && (periodic || !at_zero);
  assign expire  = !ld && tick && running && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt_q <= '0;
    else if (ld)               cnt_q <= ld_val;
    else if (tick && running)  cnt_q <= at_zero ? init_q : cnt_q - 1'b1;
  end

  a_r3_load: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> cnt_q == $past(ld_val));
  a_r4_oneshot_holds_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!periodic && at_zero && !ld) |=> at_zero);
  a_r5_periodic_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (periodic && tick && at_zero && init_q != '0 && !ld) |=> cnt_q == $past(init_q));
  a_r8_zero_init_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (init_q == '0 && !ld) |=> at_zero);
endmodule

// File: rtl/lcl_timer_irq.sv
module lcl_timer_irq
  import lcl_timer_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             expire,
  input  logic             masked,
  input  logic [VEC_W-1:0] vec_in,
  output logic             irq_valid,
  input  logic             irq_ready,
  output logic [VEC_W-1:0] irq_vector
);
  logic raise;
  logic slot_free;

  assign raise     = expire && !masked;
  assign slot_free = !irq_valid || irq_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_valid  <= 1'b0;
      irq_vector <= '0;
    end else if (raise && slot_free) begin
      irq_valid  <= 1'b1;
      irq_vector <= vec_in;
    end else if (irq_ready) begin
      irq_valid  <= 1'b0;
    end
  end

  a_r6_masked_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && masked && !irq_valid) |=> !irq_valid);
  a_r7_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && !irq_ready) |=> irq_valid && $stable(irq_vector));
  a_r10_handshake_refire: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && irq_ready && expire && !masked) |=> irq_valid);
endmodule

// File: rtl/lcl_timer.sv
module lcl_timer
  import lcl_timer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_waddr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic [1:0]        reg_raddr,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_valid,
  input  logic              irq_ready,
  output logic [7:0]        irq_vector
);
  logic [DIV_W-1:0]  div_q;
  logic [CNT_W-1:0]  init_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic              init_ld;
  logic              tick;
  logic [CNT_W-1:0]  cnt_q;
  logic              expire;

  lcl_timer_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .waddr(reg_waddr), .wdata(reg_wdata),
    .raddr(reg_raddr), .cur_cnt(cnt_q), .rdata(reg_rdata),
    .div_q(div_q), .init_q(init_q), .ctrl_q(ctrl_q), .init_ld(init_ld)
  );

  lcl_timer_prescale u_pre (
    .clk(clk), .rst_n(rst_n), .restart(init_ld),
    .shift(div_to_shift(div_q)), .tick(tick)
  );

  lcl_timer_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .ld(init_ld), .ld_val(reg_wdata[CNT_W-1:0]),
    .init_q(init_q), .periodic(ctrl_q[CTRL_PER]), .tick(tick),
    .cnt_q(cnt_q), .expire(expire)
  );

  lcl_timer_irq u_irq (
    .clk(clk), .rst_n(rst_n), .expire(expire), .masked(ctrl_q[CTRL_MASK]),
    .vec_in(ctrl_q[VEC_W-1:0]), .irq_valid(irq_valid), .irq_ready(irq_ready),
    .irq_vector(irq_vector)
  );
endmodule

// File: tb/lcl_timer_test.sv
module lcl_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_waddr = '0;
  logic [31:0] reg_wdata = '0;
  logic [1:0]  reg_raddr = '0;
  logic [31:0] reg_rdata;
  logic        irq_valid;
  logic        irq_ready = 1'b0;
  logic [7:0]  irq_vector;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  lcl_timer uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_waddr(reg_waddr),
    .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .irq_valid(irq_valid), .irq_ready(irq_ready), .irq_vector(irq_vector)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_waddr = a; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    reg_raddr = a; #1; v = reg_rdata;
  endtask

  task automatic stop_timer();
    irq_ready = 1'b1;
    wr(2'd1, 32'd0);
    irq_ready = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int a = 0; a < 4; a++) begin rd(a[1:0], v); chk("R11 reg after reset", v, 0); end
    chk("R11 irq_valid after reset", irq_valid, 0);
  endtask

  task automatic t_div_mask();
    logic [31:0] v;
    wr(2'd0, 32'hFF); rd(2'd0, v); chk("R1 divide keeps bits 0,1,3", v, 32'hB);
  endtask

  task automatic t_oneshot();
    logic [31:0] v;
    wr(2'd0, 32'hB); wr(2'd3, 32'h41); wr(2'd1, 32'd5);
    rd(2'd2, v); chk("R3 count loaded", v, 5);
    step(1); rd(2'd2, v); chk("R2 divide-by-1 step", v, 4);
    step(3); rd(2'd2, v); chk("R4 count before expiry", v, 1);
    chk("R4 no request yet", irq_valid, 0);
    step(1); rd(2'd2, v); chk("R4 count at zero", v, 0);
    chk("R4 request raised", irq_valid, 1);
    chk("R7 vector", irq_vector, 8'h41);
    step(3); rd(2'd2, v); chk("R4 count stays zero", v, 0);
    chk("R7 held without ready", irq_valid, 1);
    irq_ready = 1'b1; step(1); irq_ready = 1'b0;
    chk("R7 dropped after handshake", irq_valid, 0);
    step(4); chk("R4 only one request", irq_valid, 0);
    stop_timer();
  endtask

  task automatic t_div_default();
    logic [31:0] v;
    wr(2'd0, 32'h0); wr(2'd3, 32'h10000); wr(2'd1, 32'd2);
    step(1); rd(2'd2, v); chk("R2 divide-by-2 first edge", v, 2);
    step(1); rd(2'd2, v); chk("R2 divide-by-2 second edge", v, 1);
    stop_timer();
  endtask

  task automatic t_div8();
    logic [31:0] v;
    wr(2'd0, 32'h2); wr(2'd3, 32'h44); wr(2'd1, 32'd3);
    step(7); rd(2'd2, v); chk("R2 divide-by-8 before step", v, 3);
    step(1); rd(2'd2, v); chk("R2 divide-by-8 first step", v, 2);
    step(15); chk("R2 no request before 24 clocks", irq_valid, 0);
    step(1); rd(2'd2, v); chk("R2 zero after 24 clocks", v, 0);
    chk("R7 divide-by-8 request", irq_valid, 1);
    chk("R7 divide-by-8 vector", irq_vector, 8'h44);
    stop_timer();
  endtask

  task automatic t_periodic();
    logic [31:0] v;
    int hs = 0;
    wr(2'd0, 32'hB); irq_ready = 1'b1;
    wr(2'd3, 32'h20022); wr(2'd1, 32'd2);
    for (int i = 0; i < 9; i++) begin
      step(1);
      if (irq_valid) begin
        hs++;
        chk("R7 periodic vector", irq_vector, 8'h22);
      end
      if (i == 2) begin rd(2'd2, v); chk("R5 reload to initial", v, 2); end
    end
    chk("R5 one request per N+1 steps", hs, 3);
    irq_ready = 1'b0;
    stop_timer();
  endtask

  task automatic t_masked();
    logic [31:0] v;
    wr(2'd3, 32'h10033); wr(2'd1, 32'd2);
    step(4); rd(2'd2, v); chk("R6 masked count reached zero", v, 0);
    chk("R6 masked no request", irq_valid, 0);
    stop_timer();
  endtask

  task automatic t_zero_init();
    logic [31:0] v;
    wr(2'd3, 32'h20012); wr(2'd1, 32'd0);
    step(10); rd(2'd2, v); chk("R8 zero init stays zero", v, 0);
    chk("R8 zero init no request", irq_valid, 0);
  endtask

  task automatic t_reeval();
    logic [31:0] v;
    irq_ready = 1'b1;
    wr(2'd3, 32'h55); wr(2'd1, 32'd2);
    step(4); rd(2'd2, v); chk("R9 one-shot expired", v, 0);
    wr(2'd3, 32'h20055); rd(2'd2, v); chk("R9 still zero at control write", v, 0);
    step(1); rd(2'd2, v); chk("R9 periodic resumes with reload", v, 2);
    irq_ready = 1'b0;
    stop_timer();
  endtask

  task automatic t_collide();
    wr(2'd3, 32'h20077); wr(2'd1, 32'd1);
    step(5); chk("R10 pending after merged expiries", irq_valid, 1);
    chk("R10 vector", irq_vector, 8'h77);
    irq_ready = 1'b1; step(1); irq_ready = 1'b0;
    chk("R10 merged into one request", irq_valid, 0);
    step(1); chk("R10 next expiry raises", irq_valid, 1);
    wr(2'd3, 32'h20066);
    irq_ready = 1'b1; step(1); irq_ready = 1'b0;
    chk("R10 expiry during handshake keeps valid", irq_valid, 1);
    chk("R10 fresh vector", irq_vector, 8'h66);
    stop_timer();
  endtask

  task automatic t_curr_ro();
    logic [31:0] v;
    wr(2'd3, 32'h10000); wr(2'd1, 32'd7); wr(2'd2, 32'h99);
    rd(2'd2, v); chk("R12 write to count ignored", v, 6);
    rd(2'd1, v); chk("R12 initial count unchanged", v, 7);
    stop_timer();
  endtask

  initial begin
    fork
      begin
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        t_reset();
        t_div_mask();
        t_oneshot();
        t_div_default();
        t_div8();
        t_periodic();
        t_masked();
        t_zero_init();
        t_reeval();
        t_collide();
        t_curr_ro();
        done = 1;
      end
      begin
        repeat (20000) @(posedge clk);
        if (!done) begin
          checks++; fails++;
          $display("FAIL watchdog: actual hung expected done");
        end
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule